// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This unit decides, for one issuing load per cycle, how that load relates to the stores ahead of it in the store queue. It compares the load's byte range against every queue entry that is occupied and older than the load. From that comparison it picks one of three outcomes: hand the load data taken straight from a store, hold the load back (stall), or let it go to the cache. Every queue entry is described on flat input buses: address, byte count, whether it is a plain store or an atomic, whether it has already been written back, an age tag, and its data bytes.

Only one entry can decide the outcome. It is the youngest older entry whose overlap matters, meaning the load could forward from it, or it would stall the load and has not been written back yet. Atomic entries hold no usable data until they execute, and load-linked accesses must see the cache. Neither of them ever forwards, and any overlap with them holds the load. The result is registered. One cycle after a load is presented, the unit returns a valid pulse with the decision code, the deciding entry's index and the forwarded bytes aligned to the load address.

Top module: `stlf_checker`

## Requirements
- R1: When the deciding entry fully contains the load range, is a plain store (ent_atomic=0) and the load is not load-linked (ld_linked=0), the decision is forward (res_dec=1) and res_idx names that entry.
- R2: Forwarded data byte b equals the store's data byte (b + ld_addr - store_addr) for b < ld_size. Store byte k sits at bits [8k+7:8k] of the entry's data field, and result bytes at or above ld_size are zero.
- R3: A load-linked load that overlaps a deciding store, fully or partly, gets stall (res_dec=2) with res_idx naming that entry, and is never forwarded.
- R4: For an ordinary load, a deciding store that covers only the low part, only the high part, or lies strictly inside the load range causes stall (res_dec=2).
- R5: Any overlap, full or partial, with a deciding atomic entry causes stall (res_dec=2) and never forward.
- R6: An overlapping entry with ent_wb=1 that would stall the load is skipped, and the search goes on to older entries. A written-back entry that can forward still forwards.
- R7: When several entries qualify, the one with the largest age tag decides, so younger stores shadow older ones.
- R8: Only entries with ent_valid=1 and an age tag strictly below ld_age take part.
- R9: Ranges are half-open [addr, addr+size). Adjacent ranges do not overlap, and an entry or load with size zero never matches.
- R10: When no entry decides, the decision is cache (res_dec=0) with res_idx=0 and res_data=0. Stall results also carry res_data=0.
- R11: A result with res_valid=1 appears on the clock edge after a cycle with ld_valid=1. After a cycle with ld_valid=0, res_valid, res_dec, res_idx and res_data are all zero.
- R12: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SIZE_W | Load byte count, 0..DATA_BYTES |
| ld_linked | input | 1 | Load is a load-linked access |
| ld_age | input | AGE_W | Load age tag; entries with smaller tags are older |
| ent_valid | input | NUM_ENT | Entry occupied |
| ent_addr | input | NUM_ENT*ADDR_W | Entry addresses, entry i at [i*ADDR_W +: ADDR_W] |
| ent_size | input | NUM_ENT*SIZE_W | Entry byte counts |
| ent_atomic | input | NUM_ENT | Entry is an atomic |
| ent_wb | input | NUM_ENT | Entry already written back to the cache |
| ent_age | input | NUM_ENT*AGE_W | Entry age tags |
| ent_data | input | NUM_ENT*DATA_BYTES*8 | Entry data, byte 0 lowest |
| res_valid | output | 1 | Result pulse |
| res_dec | output | 2 | 0 cache, 1 forward, 2 stall |
| res_idx | output | IDX_W | Deciding entry index |
| res_data | output | DATA_BYTES*8 | Forwarded data aligned to the load address |

## Verification
The bench targets the range boundaries first: loads that end exactly where a store starts, zero-size loads and entries, and stores that cover only one edge of the load. A design using closed ranges or testing only the start address would wrongly stall or forward in these cases. It then stacks several overlapping entries to check that the youngest one decides. It also checks that entries which are younger, unoccupied or written back and stalling are passed over, since a design that got this wrong would stall on a store that no longer matters or forward stale bytes. Finally, atomic entries and load-linked loads are driven with exact full-cover ranges, where a careless design would forward.

// File: rtl/stlf_pkg.sv
package stlf_pkg;

    typedef enum logic [1:0] {
        DEC_CACHE = 2'd0,
        DEC_FWD   = 2'd1,
        DEC_STALL = 2'd2
    } stlf_dec_e;

endpackage

// File: rtl/stlf_entry_cmp.sv
module stlf_entry_cmp #(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 4,
    parameter int AGE_W  = 4
) (
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic              ld_linked,
    input  logic [AGE_W-1:0]  ld_age,
    input  logic              e_valid,
    input  logic [ADDR_W-1:0] e_addr,
    input  logic [SIZE_W-1:0] e_size,
    input  logic              e_atomic,
    input  logic              e_wb,
    input  logic [AGE_W-1:0]  e_age,
    output logic              decisive,
    output logic              fwd_ok
);

    localparam int EW = ADDR_W + 1;

    logic [EW-1:0] ld_lo, ld_hi, st_lo, st_hi;
    logic          older, overlap, covers;

    always_comb begin
        ld_lo   = {1'b0, ld_addr};
        ld_hi   = ld_lo + EW'(ld_size);
        st_lo   = {1'b0, e_addr};
        st_hi   = st_lo + EW'(e_size);
        older   = e_valid && (e_age < ld_age);
        overlap = (ld_size != '0) && (e_size != '0) &&
                  (ld_lo < st_hi) && (st_lo < ld_hi);
        covers  = overlap && (st_lo <= ld_lo) && (ld_hi <= st_hi);
        fwd_ok  = older && covers && !e_atomic && !ld_linked;
        // a written-back entry only matters if it can forward
        decisive = older && overlap && (fwd_ok || !e_wb);
    end

endmodule

// File: rtl/stlf_pick.sv
module stlf_pick #(
    parameter int NUM_ENT = 4,
    parameter int AGE_W   = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_ENT-1:0]       cand,
    input  logic [NUM_ENT*AGE_W-1:0] ages,
    output logic                     hit,
    output logic [IDX_W-1:0]         idx
);

    logic [AGE_W-1:0] best_age;

    always_comb begin
        hit      = 1'b0;
        idx      = '0;
        best_age = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (cand[i] && (!hit || ages[i*AGE_W +: AGE_W] > best_age)) begin
                hit      = 1'b1;
                idx      = IDX_W'(i);
                best_age = ages[i*AGE_W +: AGE_W];
            end
        end
    end

endmodule

// File: rtl/stlf_align.sv
module stlf_align #(
    parameter int DATA_BYTES = 8,
    parameter int SIZE_W     = 4,
    parameter int OFF_W      = 3
) (
    input  logic [DATA_BYTES*8-1:0] src_data,
    input  logic [OFF_W-1:0]        offset,
    input  logic [SIZE_W-1:0]       ld_size,
    output logic [DATA_BYTES*8-1:0] out_data
);

    always_comb begin
        out_data = '0;
        for (int b = 0; b < DATA_BYTES; b++) begin
            int src;
            int src_c;
            src   = b + int'(offset);
            src_c = (src < DATA_BYTES) ? src : 0;
            if ((b < int'(ld_size)) && (src < DATA_BYTES)) begin
                out_data[b*8 +: 8] = src_data[src_c*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/stlf_checker.sv
module stlf_checker
    import stlf_pkg::*;
#(
    parameter int NUM_ENT    = 4,
    parameter int ADDR_W     = 16,
    parameter int DATA_BYTES = 8,
    parameter int AGE_W      = 4,
    parameter int SIZE_W     = $clog2(DATA_BYTES + 1),
    parameter int IDX_W      = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ld_valid,
    input  logic [ADDR_W-1:0]               ld_addr,
    input  logic [SIZE_W-1:0]               ld_size,
    input  logic                            ld_linked,
    input  logic [AGE_W-1:0]                ld_age,
    input  logic [NUM_ENT-1:0]              ent_valid,
    input  logic [NUM_ENT*ADDR_W-1:0]       ent_addr,
    input  logic [NUM_ENT*SIZE_W-1:0]       ent_size,
    input  logic [NUM_ENT-1:0]              ent_atomic,
    input  logic [NUM_ENT-1:0]              ent_wb,
    input  logic [NUM_ENT*AGE_W-1:0]        ent_age,
    input  logic [NUM_ENT*DATA_BYTES*8-1:0] ent_data,
    output logic                            res_valid,
    output logic [1:0]                      res_dec,
    output logic [IDX_W-1:0]                res_idx,
    output logic [DATA_BYTES*8-1:0]         res_data
);

    localparam int DW    = DATA_BYTES * 8;
    localparam int OFF_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
    localparam logic [NUM_ENT-1:0] ENT_ONE = NUM_ENT'(1);

    typedef struct packed {
        logic             vld;
        stlf_dec_e        dec;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    data;
    } res_t;

    logic [NUM_ENT-1:0] cand;
    logic [NUM_ENT-1:0] fwd_ok;
    logic               sel_hit;
    logic [IDX_W-1:0]   sel_idx;
    logic [ADDR_W-1:0]  sel_addr;
    logic [DW-1:0]      sel_data;
    logic [OFF_W-1:0]   sel_off;
    logic [DW-1:0]      aligned;
    res_t               res_d, res_q;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        stlf_entry_cmp #(
            .ADDR_W (ADDR_W),
            .SIZE_W (SIZE_W),
            .AGE_W  (AGE_W)
        ) u_cmp (
            .ld_addr   (ld_addr),
            .ld_size   (ld_size),
            .ld_linked (ld_linked),
            .ld_age    (ld_age),
            .e_valid   (ent_valid[g]),
            .e_addr    (ent_addr[g*ADDR_W +: ADDR_W]),
            .e_size    (ent_size[g*SIZE_W +: SIZE_W]),
            .e_atomic  (ent_atomic[g]),
            .e_wb      (ent_wb[g]),
            .e_age     (ent_age[g*AGE_W +: AGE_W]),
            .decisive  (cand[g]),
            .fwd_ok    (fwd_ok[g])
        );
    end

    stlf_pick #(
        .NUM_ENT (NUM_ENT),
        .AGE_W   (AGE_W),
        .IDX_W   (IDX_W)
    ) u_pick (
        .cand (cand),
        .ages (ent_age),
        .hit  (sel_hit),
        .idx  (sel_idx)
    );

    always_comb begin
        sel_addr = ent_addr[sel_idx*ADDR_W +: ADDR_W];
        sel_data = ent_data[sel_idx*DW +: DW];
        sel_off  = ld_addr[OFF_W-1:0] - sel_addr[OFF_W-1:0];
    end

    stlf_align #(
        .DATA_BYTES (DATA_BYTES),
        .SIZE_W     (SIZE_W),
        .OFF_W      (OFF_W)
    ) u_align (
        .src_data (sel_data),
        .offset   (sel_off),
        .ld_size  (ld_size),
        .out_data (aligned)
    );

    always_comb begin
        res_d = '0;
        if (ld_valid) begin
            res_d.vld = 1'b1;
            if (!sel_hit) begin
                res_d.dec = DEC_CACHE;
            end else if (fwd_ok[sel_idx]) begin
                res_d.dec  = DEC_FWD;
                res_d.idx  = sel_idx;
                res_d.data = aligned;
            end else begin
                res_d.dec = DEC_STALL;
                res_d.idx = sel_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.vld;
    assign res_dec   = res_q.dec;
    assign res_idx   = res_q.idx;
    assign res_data  = res_q.data;

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> res_valid); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> (!res_valid && res_dec == 2'd0 && res_data == '0)); // R11
    AST_FWD_NOT_LINKED: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_dec == 2'd1) |-> !$past(ld_linked)); // R3
    AST_FWD_NOT_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_dec == 2'd1) |->
            ($past(ent_atomic) & (ENT_ONE << res_idx)) == '0); // R5
    AST_HIT_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_dec != 2'd0) |->
            ($past(ent_valid) & (ENT_ONE << res_idx)) != '0); // R8
    AST_NO_DATA_UNLESS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_dec != 2'd1) |-> (res_data == '0)); // R10
    AST_CACHE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_dec == 2'd0) |-> (res_idx == '0)); // R10
    AST_DEC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        res_dec != 2'd3); // R1

endmodule

// File: tb/stlf_checker_test.sv
`timescale 1ns/1ps
module stlf_checker_test;

    localparam int N  = 4;
    localparam int AW = 16;
    localparam int DB = 8;
    localparam int GW = 4;
    localparam int SW = 4;
    localparam int IW = 2;

    typedef struct packed {
        logic [1:0]  scn;
        logic [15:0] addr;
        logic [3:0]  size;
        logic        linked;
        logic [3:0]  age;
        logic [1:0]  dec;
        logic [1:0]  idx;
        logic [3:0]  off;
        logic [3:0]  req;
    } vec_t;

    // dec: 0 cache, 1 forward, 2 stall
    localparam vec_t VECS [20] = '{
        '{2'd0, 16'h0100, 4'd8, 1'b0, 4'd10, 2'd2, 2'd1, 4'd0, 4'd4},  // R4 store inside load, R7
        '{2'd0, 16'h0104, 4'd4, 1'b0, 4'd10, 2'd1, 2'd1, 4'd0, 4'd1},  // R1 R7
        '{2'd0, 16'h0102, 4'd2, 1'b0, 4'd10, 2'd1, 2'd0, 4'd2, 4'd2},  // R2
        '{2'd0, 16'h0106, 4'd4, 1'b0, 4'd10, 2'd2, 2'd1, 4'd0, 4'd4},  // R4 low part
        '{2'd0, 16'h00FE, 4'd4, 1'b0, 4'd10, 2'd2, 2'd0, 4'd0, 4'd4},  // R4 high part
        '{2'd0, 16'h0200, 4'd4, 1'b0, 4'd10, 2'd2, 2'd2, 4'd0, 4'd5},  // R5 full atomic
        '{2'd0, 16'h0207, 4'd2, 1'b0, 4'd10, 2'd2, 2'd2, 4'd0, 4'd5},  // R5 partial atomic
        '{2'd0, 16'h0302, 4'd2, 1'b0, 4'd10, 2'd0, 2'd0, 4'd0, 4'd9},  // R9 adjacent above
        '{2'd0, 16'h02FF, 4'd1, 1'b0, 4'd10, 2'd0, 2'd0, 4'd0, 4'd10}, // R10 R9 adjacent below
        '{2'd0, 16'h0300, 4'd2, 1'b1, 4'd10, 2'd2, 2'd3, 4'd0, 4'd3},  // R3 full
        '{2'd0, 16'h0104, 4'd2, 1'b1, 4'd10, 2'd2, 2'd1, 4'd0, 4'd3},  // R3
        '{2'd0, 16'h0300, 4'd2, 1'b0, 4'd4,  2'd0, 2'd0, 4'd0, 4'd8},  // R8 equal age
        '{2'd0, 16'h0104, 4'd4, 1'b0, 4'd2,  2'd1, 2'd0, 4'd4, 4'd8},  // R8 R2
        '{2'd0, 16'h0300, 4'd1, 1'b0, 4'd10, 2'd1, 2'd3, 4'd0, 4'd1},  // R1
        '{2'd1, 16'h0100, 4'd4, 1'b0, 4'd10, 2'd1, 2'd0, 4'd0, 4'd6},  // R6 skip wb
        '{2'd1, 16'h0400, 4'd8, 1'b0, 4'd10, 2'd1, 2'd3, 4'd0, 4'd6},  // R6 wb forwards
        '{2'd1, 16'h0100, 4'd4, 1'b1, 4'd10, 2'd2, 2'd0, 4'd0, 4'd6},  // R6 R3
        '{2'd2, 16'h0500, 4'd8, 1'b0, 4'd8,  2'd1, 2'd0, 4'd0, 4'd8},  // R8 R9 zero-size entry
        '{2'd2, 16'h0504, 4'd0, 1'b0, 4'd8,  2'd0, 2'd0, 4'd0, 4'd9},  // R9 zero-size load
        '{2'd0, 16'h0105, 4'd3, 1'b0, 4'd10, 2'd1, 2'd1, 4'd1, 4'd2}   // R2 offset, short size
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ld_valid = 1'b0;
    logic [AW-1:0]   ld_addr = '0;
    logic [SW-1:0]   ld_size = '0;
    logic            ld_linked = 1'b0;
    logic [GW-1:0]   ld_age = '0;
    logic [N-1:0]    ent_valid = '0;
    logic [N*AW-1:0] ent_addr = '0;
    logic [N*SW-1:0] ent_size = '0;
    logic [N-1:0]    ent_atomic = '0;
    logic [N-1:0]    ent_wb = '0;
    logic [N*GW-1:0] ent_age = '0;
    logic [N*DB*8-1:0] ent_data = '0;
    logic            res_valid;
    logic [1:0]      res_dec;
    logic [IW-1:0]   res_idx;
    logic [DB*8-1:0] res_data;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    stlf_checker uut (
        .clk (clk), .rst_n (rst_n), .ld_valid (ld_valid), .ld_addr (ld_addr),
        .ld_size (ld_size), .ld_linked (ld_linked), .ld_age (ld_age),
        .ent_valid (ent_valid), .ent_addr (ent_addr), .ent_size (ent_size),
        .ent_atomic (ent_atomic), .ent_wb (ent_wb), .ent_age (ent_age),
        .ent_data (ent_data), .res_valid (res_valid), .res_dec (res_dec),
        .res_idx (res_idx), .res_data (res_data)
    );

    function automatic logic [63:0] pat_byte_word(input int e, input int off, input int sz);
        logic [63:0] w;
        w = '0;
        for (int b = 0; b < 8; b++) begin
            if (b < sz) w[b*8 +: 8] = 8'(((e + 1) << 4) | (b + off));
        end
        return w;
    endfunction

    task automatic set_ent(input int i, input logic v, input logic [15:0] a,
                           input logic [3:0] s, input logic at, input logic wb,
                           input logic [3:0] g);
        ent_valid[i]          = v;
        ent_addr[i*AW +: AW]  = a;
        ent_size[i*SW +: SW]  = s;
        ent_atomic[i]         = at;
        ent_wb[i]             = wb;
        ent_age[i*GW +: GW]   = g;
        ent_data[i*64 +: 64]  = pat_byte_word(i, 0, 8);
    endtask

    task automatic load_scn(input int s);
        case (s)
            0: begin
                set_ent(0, 1'b1, 16'h0100, 4'd8, 1'b0, 1'b0, 4'd1);
                set_ent(1, 1'b1, 16'h0104, 4'd4, 1'b0, 1'b0, 4'd2);
                set_ent(2, 1'b1, 16'h0200, 4'd8, 1'b1, 1'b0, 4'd3);
                set_ent(3, 1'b1, 16'h0300, 4'd2, 1'b0, 1'b0, 4'd4);
            end
            1: begin
                set_ent(0, 1'b1, 16'h0100, 4'd8, 1'b0, 1'b0, 4'd1);
                set_ent(1, 1'b1, 16'h0102, 4'd2, 1'b0, 1'b1, 4'd3);
                set_ent(2, 1'b1, 16'h0100, 4'd4, 1'b1, 1'b1, 4'd5);
                set_ent(3, 1'b1, 16'h0400, 4'd8, 1'b0, 1'b1, 4'd2);
            end
            default: begin
                set_ent(0, 1'b1, 16'h0500, 4'd8, 1'b0, 1'b0, 4'd1);
                set_ent(1, 1'b0, 16'h0500, 4'd8, 1'b0, 1'b0, 4'd6);
                set_ent(2, 1'b1, 16'h0500, 4'd8, 1'b0, 1'b0, 4'd9);
                set_ent(3, 1'b1, 16'h0504, 4'd0, 1'b0, 1'b0, 4'd7);
            end
        endcase
    endtask

    task automatic check(input string req, input logic v, input logic [1:0] d,
                         input logic [1:0] ix, input logic [63:0] dat);
        checks++;
        if (res_valid !== v || res_dec !== d || res_idx !== ix || res_data !== dat) begin
            failures++;
            $display("FAIL %s: actual v=%0b dec=%0d idx=%0d data=%h expected v=%0b dec=%0d idx=%0d data=%h",
                     req, res_valid, res_dec, res_idx, res_data, v, d, ix, dat);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R12: outputs zero in reset, even with a load presented
        load_scn(0);
        ld_valid = 1'b1; ld_addr = 16'h0104; ld_size = 4'd4; ld_age = 4'd10;
        repeat (3) @(negedge clk);
        check("R12", 1'b0, 2'd0, 2'd0, 64'd0);
        ld_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", 1'b0, 2'd0, 2'd0, 64'd0);

        for (int k = 0; k < 20; k++) begin
            vec_t vv;
            logic [63:0] exp_d;
            vv = VECS[k];
            load_scn(int'(vv.scn));
            ld_valid  = 1'b1;
            ld_addr   = vv.addr;
            ld_size   = vv.size;
            ld_linked = vv.linked;
            ld_age    = vv.age;
            exp_d = (vv.dec == 2'd1) ?
                    pat_byte_word(int'(vv.idx), int'(vv.off), int'(vv.size)) : 64'd0;
            @(negedge clk);
            check($sformatf("R%0d vec%0d", vv.req, k), 1'b1, vv.dec, vv.idx, exp_d);
        end

        // R11: idle cycle clears the result after a forward
        load_scn(0);
        ld_addr = 16'h0104; ld_size = 4'd4; ld_linked = 1'b0; ld_age = 4'd10;
        @(negedge clk);
        check("R11 fwd", 1'b1, 2'd1, 2'd1, 64'h0000_0000_2322_2120);
        ld_valid = 1'b0;
        @(negedge clk);
        check("R11 idle", 1'b0, 2'd0, 2'd0, 64'd0);

        // R7: every entry overlapping with distinct ages; youngest (entry 2) decides
        set_ent(0, 1'b1, 16'h0600, 4'd8, 1'b0, 1'b0, 4'd3);
        set_ent(1, 1'b1, 16'h0600, 4'd8, 1'b0, 1'b0, 4'd1);
        set_ent(2, 1'b1, 16'h0600, 4'd8, 1'b0, 1'b0, 4'd7);
        set_ent(3, 1'b1, 16'h0600, 4'd8, 1'b0, 1'b0, 4'd5);
        ld_valid = 1'b1; ld_addr = 16'h0602; ld_size = 4'd2; ld_age = 4'd9;
        @(negedge clk);
        check("R7 youngest", 1'b1, 2'd1, 2'd2, pat_byte_word(2, 2, 2));
        // R6: youngest becomes a written-back atomic, next youngest (entry 3) decides
        ent_atomic[2] = 1'b1; ent_wb[2] = 1'b1;
        @(negedge clk);
        check("R6 skip", 1'b1, 2'd1, 2'd3, pat_byte_word(3, 2, 2));
        // R5: same atomic not written back now stalls
        ent_wb[2] = 1'b0;
        @(negedge clk);
        check("R5 atomic", 1'b1, 2'd2, 2'd2, 64'd0);
        ld_valid = 1'b0;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule